// File: doc/BRIEF.md
# Synchronous Burst Write Slave Interface

This block is the slave side of a synchronous host bus. It takes 32-bit sequential burst writes from a processor. The processor places the start address on its own address lines, so address and data are not shared. It holds select low and pulses the strobe low for one clock. The block then takes the start address and the memory-or-register flag. After a fixed wait set by a parameter, it drives its ready output low. On every rising edge where ready is low and select is still low, the block takes one data beat.

Each accepted beat is turned into one registered write, one cycle later, on a plain write port. The write carries a word address, 32-bit data, two half-word enables and the memory-or-register flag. The word address starts at the captured base and steps by one for each beat. A beat taken while the last-word input is low ends the burst.

A full flag from the block's command FIFO drives the stop output. While the FIFO is full, no beats are taken. Raising select in the middle of a burst aborts it without writing the beat that was pending.

Top module: `sbw_burst_wr_slave`

## Requirements
- R1: In idle, a rising edge with sel_ni low and strb_ni low starts a burst and captures addr_i and mem_nreg_i. A low strb_ni with sel_ni high starts nothing.
- R2: rdy_no goes low at the WAIT_CYC-th rising edge after the start edge, provided the FIFO is not full. The first beat is taken at the edge that follows.
- R3: At each rising edge where rdy_no is low and sel_ni is low, the block accepts data_i and word_en_i. In the next cycle wr_en_o is high, with wr_data_o equal to that data and wr_hen_o equal to word_en_i. Bit 0 of the enables covers data bits 15:0 and bit 1 covers bits 31:16.
- R4: The first beat's wr_addr_o equals the captured base address. Each later accepted beat in the same burst uses the previous address plus one.
- R5: A beat accepted while last_ni is low is the final beat. rdy_no is high in the next cycle. A further burst needs a new strobe.
- R6: mem_nreg_i = 1 selects memory and 0 selects registers. A register beat whose word_en_i is not 2'b11 produces no wr_en_o, but it still advances the address.
- R7: stop_no is the inverse of fifo_full_i in the same cycle.
- R8: If fifo_full_i is high at a rising edge, rdy_no is high for the following cycle and no beat is taken in it. The burst resumes once the FIFO has room again.
- R9: If sel_ni is high at a rising edge while the block is waiting or in a burst, the block returns to idle. rdy_no is high next cycle, and no write follows for that edge.
- R10: While rst_ni is low, rdy_no is high, wr_en_o is low and the burst state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| strb_ni | input | 1 | One-cycle burst start strobe, active low |
| addr_i | input | ADDR_W | Burst base word address |
| mem_nreg_i | input | 1 | 1 = memory access, 0 = register access |
| word_en_i | input | 2 | Half-word enables, bit 0 = low half |
| last_ni | input | 1 | Final-beat marker, active low |
| data_i | input | 32 | Write data |
| fifo_full_i | input | 1 | Command FIFO full flag |
| rdy_no | output | 1 | Ready, active low: a beat is taken at the next edge |
| stop_no | output | 1 | Stop, active low, follows FIFO full |
| wr_en_o | output | 1 | Write strobe toward memory or registers |
| wr_addr_o | output | ADDR_W | Write word address |
| wr_data_o | output | 32 | Write data |
| wr_hen_o | output | 2 | Half-word write enables |
| wr_mem_o | output | 1 | 1 = memory write, 0 = register write |

## Verification
The bench uses a non-zero wait latency, so a design that counts its wait one cycle off raises ready at the wrong edge and takes the wrong beat. It stalls a burst with FIFO-full and aborts bursts both during the wait and in the middle of data. A design that keeps taking beats under stop, or that writes the beat pending at an abort, shows extra or shifted writes. A register burst with a partial enable checks that only that beat is dropped while the address still steps. A stray strobe without select checks that no burst starts.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = HALF_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } sbw_state_e;
endpackage

// File: rtl/sbw_seq_ctrl.sv
module sbw_seq_ctrl
  import sbw_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic strb_ni,
  input  logic last_ni,
  input  logic fifo_full_i,
  output logic start_o,
  output logic accept_o,
  output logic rdy_no
);
  localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  sbw_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_n_q;

  assign start_o  = (st_q == ST_IDLE) & ~sel_ni & ~strb_ni;
  assign accept_o = (st_q == ST_BURST) & ~rdy_n_q & ~sel_ni;
  assign rdy_no   = rdy_n_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_o) begin
          st_d  = ST_WAIT;
          cnt_d = CNT_LOAD;
        end
      end
      ST_WAIT: begin
        if (sel_ni)              st_d = ST_IDLE;
        else if (cnt_q == '0)    st_d = ST_BURST;
        else                     cnt_d = cnt_q - 1'b1;
      end
      ST_BURST: begin
        if (sel_ni)                    st_d = ST_IDLE;  // abort
        else if (accept_o && !last_ni) st_d = ST_IDLE;  // final beat
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rdy_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      // ready only in burst state with FIFO room
      rdy_n_q <= ~((st_d == ST_BURST) & ~fifo_full_i);
    end
  end
endmodule

// File: rtl/sbw_addr_gen.sv
module sbw_addr_gen #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_nreg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mem_q  <= 1'b1;
    end else if (start_i) begin
      addr_q <= addr_i;
      mem_q  <= mem_nreg_i;
    end else if (accept_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign mem_o  = mem_q;
endmodule

// File: rtl/sbw_wr_stage.sv
module sbw_wr_stage
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  word_en_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_hen_o,
  output logic              wr_mem_o
);
  logic              legal;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mem_q;

  // register accesses need every lane enabled
  assign legal = mem_i | (&word_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      mem_q  <= 1'b1;
    end else begin
      en_q <= accept_i & legal;
      if (accept_i) begin
        addr_q <= addr_i;
        mem_q  <= mem_i;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] h_q;
    logic              e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        h_q <= '0;
        e_q <= 1'b0;
      end else if (accept_i) begin
        h_q <= data_i[g*HALF_W +: HALF_W];
        e_q <= word_en_i[g];
      end
    end
    assign wr_data_o[g*HALF_W +: HALF_W] = h_q;
    assign wr_hen_o[g]                   = e_q;
  end

  assign wr_en_o   = en_q;
  assign wr_addr_o = addr_q;
  assign wr_mem_o  = mem_q;
endmodule

// File: rtl/sbw_burst_wr_slave.sv
module sbw_burst_wr_slave
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              strb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_nreg_i,
  input  logic [LANES-1:0]  word_en_i,
  input  logic              last_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fifo_full_i,
  output logic              rdy_no,
  output logic              stop_no,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_hen_o,
  output logic              wr_mem_o
);
  logic              start, accept;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_mem;

  assign stop_no = ~fifo_full_i;

  sbw_seq_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_ni     (sel_ni),
    .strb_ni    (strb_ni),
    .last_ni    (last_ni),
    .fifo_full_i(fifo_full_i),
    .start_o    (start),
    .accept_o   (accept),
    .rdy_no     (rdy_no)
  );

  sbw_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .mem_nreg_i(mem_nreg_i),
    .addr_o    (cur_addr),
    .mem_o     (cur_mem)
  );

  sbw_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (cur_addr),
    .mem_i    (cur_mem),
    .data_i   (data_i),
    .word_en_i(word_en_i),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .wr_hen_o (wr_hen_o),
    .wr_mem_o (wr_mem_o)
  );
endmodule

// File: rtl/sbw_burst_wr_slave_chk.sv
module sbw_burst_wr_slave_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_ni,
  input logic              last_ni,
  input logic              fifo_full_i,
  input logic              rdy_no,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [1:0]        wr_hen_o,
  input logic              wr_mem_o
);
  assert_reg_both_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_mem_o) |-> (wr_hen_o == 2'b11));

  assert_full_blocks_rdy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |=> rdy_no);

  assert_write_after_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!rdy_no && !sel_ni));

  assert_last_releases_rdy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && !sel_ni && !last_ni) |=> rdy_no);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1)));

  assert_abort_rdy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> rdy_no);
endmodule

bind sbw_burst_wr_slave sbw_burst_wr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_ni     (sel_ni),
  .last_ni    (last_ni),
  .fifo_full_i(fifo_full_i),
  .rdy_no     (rdy_no),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .wr_hen_o   (wr_hen_o),
  .wr_mem_o   (wr_mem_o)
);

// File: tb/sbw_burst_wr_slave_tb.sv
module sbw_burst_wr_slave_tb_top;
  localparam int AW = 16;
  localparam int W  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1, strb_n = 1'b1, mem_n = 1'b1, last_n = 1'b1, full = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    we = 2'b11;
  logic [31:0]   data = '0;
  logic          rdy_no, stop_no, wr_en_o, wr_mem_o;
  logic [AW-1:0] wr_addr_o;
  logic [31:0]   wr_data_o;
  logic [1:0]    wr_hen_o;

  always #4 clk = ~clk;

  sbw_burst_wr_slave #(.ADDR_W(AW), .WAIT_CYC(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .strb_ni(strb_n), .addr_i(addr),
    .mem_nreg_i(mem_n), .word_en_i(we), .last_ni(last_n), .data_i(data),
    .fifo_full_i(full), .rdy_no(rdy_no), .stop_no(stop_no), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_hen_o(wr_hen_o), .wr_mem_o(wr_mem_o)
  );

  int    n_chk = 0, n_err = 0;
  string cur_req = "R10";
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int            m_phase = 0;   // 0 idle, 1 waiting, 2 data
  int            m_left = 0;
  bit            m_rdy_n = 1;
  logic [AW-1:0] m_addr = '0;
  bit            m_mem = 1;
  bit            e_wr = 0, e_mem = 1;
  logic [AW-1:0] e_addr = '0;
  logic [31:0]   e_data = '0;
  logic [1:0]    e_hen = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_rdy_n = 1; e_wr = 0;
    end else begin
      bit take;
      take = (m_phase == 2) && !m_rdy_n && !sel_n;
      e_wr = 0;
      if (take) begin
        e_wr = m_mem || (we == 2'b11);
        e_addr = m_addr; e_data = data; e_hen = we; e_mem = m_mem;
        m_addr = m_addr + 1;
      end
      if (m_phase == 0) begin
        if (!sel_n && !strb_n) begin
          m_phase = 1; m_left = W; m_addr = addr; m_mem = mem_n;
        end
      end else if (m_phase == 1) begin
        if (sel_n) m_phase = 0;
        else begin
          m_left--;
          if (m_left == 0) m_phase = 2;
        end
      end else begin
        if (sel_n) m_phase = 0;
        else if (take && !last_n) m_phase = 0;
      end
      m_rdy_n = !((m_phase == 2) && !full);
    end
  end

  logic [AW-1:0] obs_addr[$];
  logic [1:0]    obs_hen[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdy_no == m_rdy_n, cur_req, "rdy_no", rdy_no, m_rdy_n);
      chk(stop_no == !full, "R7", "stop_no", stop_no, !full);
      chk(wr_en_o == e_wr, cur_req, "wr_en_o", wr_en_o, e_wr);
      if (wr_en_o && e_wr) begin
        chk(wr_addr_o == e_addr, cur_req, "wr_addr_o", wr_addr_o, e_addr);
        chk(wr_data_o == e_data, cur_req, "wr_data_o", wr_data_o, e_data);
        chk(wr_hen_o == e_hen, cur_req, "wr_hen_o", wr_hen_o, e_hen);
        chk(wr_mem_o == e_mem, cur_req, "wr_mem_o", wr_mem_o, e_mem);
      end
      if (wr_en_o) begin
        obs_addr.push_back(wr_addr_o);
        obs_hen.push_back(wr_hen_o);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic start(input logic [AW-1:0] a, input bit m);
    sel_n = 0; strb_n = 0; addr = a; mem_n = m;
    step(1);
    strb_n = 1;
  endtask

  task automatic send(input int n, input logic [31:0] seed, input logic [7:0] pat,
                      input int abort_at);
    int  i = 0;
    bit  r;
    while (i < n) begin
      if (i == abort_at) begin
        sel_n = 1; last_n = 1;
        break;
      end
      data = seed + 32'(i) * 32'h0101_0101;
      we = pat[(i % 4) * 2 +: 2];
      last_n = (i == n - 1) ? 1'b0 : 1'b1;
      r = rdy_no;
      step(1);
      if (!r) i++;
    end
    last_n = 1; sel_n = 1; we = 2'b11;
    step(2);
  endtask

  initial begin
    step(2);
    chk(rdy_no == 1'b1, "R10", "reset rdy_no", rdy_no, 1);
    chk(wr_en_o == 1'b0, "R10", "reset wr_en_o", wr_en_o, 0);
    chk(stop_no == 1'b1, "R7", "reset stop_no", stop_no, 1);
    rst_n = 1;
    step(2);

    // stray strobe without select
    cur_req = "R1";
    obs_addr.delete();
    strb_n = 0; step(1); strb_n = 1; step(W + 3);
    chk(obs_addr.size() == 0, "R1", "writes after stray strobe", obs_addr.size(), 0);
    chk(rdy_no == 1'b1, "R1", "rdy after stray strobe", rdy_no, 1);

    // plain memory burst with latency measurement
    cur_req = "R2";
    obs_addr.delete();
    start(16'h0100, 1);
    begin
      int k = 0;
      while (rdy_no && k < 20) begin step(1); k++; end
      chk(k == W, "R2", "edges to ready", k, W);
    end
    send(4, 32'hA000_0000, 8'hFF, -1);
    chk(obs_addr.size() == 4, "R5", "beats in burst", obs_addr.size(), 4);
    chk(obs_addr.size() > 0 && obs_addr[0] == 16'h0100, "R1", "base addr",
        obs_addr.size() > 0 ? obs_addr[0] : 0, 16'h0100);
    chk(obs_addr.size() == 4 && obs_addr[3] == 16'h0103, "R4", "last addr",
        obs_addr.size() == 4 ? obs_addr[3] : 0, 16'h0103);
    chk(rdy_no == 1'b1, "R5", "rdy after last", rdy_no, 1);

    // varied half-word enables: 11, 01, 10, 00
    cur_req = "R3";
    obs_addr.delete(); obs_hen.delete();
    start(16'h0200, 1);
    send(4, 32'h1234_5678, 8'b00_10_01_11, -1);
    chk(obs_hen.size() == 4, "R3", "enable beats", obs_hen.size(), 4);
    chk(obs_hen.size() == 4 && obs_hen[2] == 2'b10, "R3", "hen beat2",
        obs_hen.size() == 4 ? obs_hen[2] : 0, 2'b10);

    // register burst with one partial enable
    cur_req = "R6";
    obs_addr.delete();
    start(16'h0040, 0);
    send(3, 32'h0BAD_F00D, 8'b00_11_01_11, -1);
    chk(obs_addr.size() == 2, "R6", "register writes", obs_addr.size(), 2);
    chk(obs_addr.size() == 2 && obs_addr[1] == 16'h0042, "R6", "addr after drop",
        obs_addr.size() == 2 ? obs_addr[1] : 0, 16'h0042);

    // FIFO full stalls the burst
    cur_req = "R8";
    obs_addr.delete();
    fork
      begin start(16'h0300, 1); send(6, 32'h5555_0000, 8'hFF, -1); end
      begin step(W + 3); full = 1; step(3); full = 0; end
    join
    chk(obs_addr.size() == 6, "R8", "writes across stall", obs_addr.size(), 6);

    // abort in data phase
    cur_req = "R9";
    obs_addr.delete();
    start(16'h0400, 1);
    send(5, 32'h7700_0000, 8'hFF, 2);
    chk(obs_addr.size() == 2, "R9", "writes before abort", obs_addr.size(), 2);
    chk(rdy_no == 1'b1, "R9", "rdy after abort", rdy_no, 1);

    // abort in wait phase
    obs_addr.delete();
    start(16'h0500, 1);
    sel_n = 1;
    step(W + 3);
    chk(obs_addr.size() == 0, "R9", "writes after wait abort", obs_addr.size(), 0);
    chk(rdy_no == 1'b1, "R9", "rdy after wait abort", rdy_no, 1);

    // burst after aborts still works
    cur_req = "R4";
    obs_addr.delete();
    start(16'hFFFE, 1);
    send(3, 32'hCAFE_0000, 8'hFF, -1);
    chk(obs_addr.size() == 3 && obs_addr[2] == 16'h0000, "R4", "address wrap",
        obs_addr.size() == 3 ? obs_addr[2] : 16'h1, 16'h0000);

    step(3);
    finish_run();
  end
endmodule